// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. On each edge the program counter, the register bank and the data array all update together. The instruction word is fetched, decoded and executed, and its result is written back, within the same cycle. The clock period is therefore bounded by the longest combinational route, which is the load path: fetch, register read, address add, data-array read, write-back mux. The core runs a small subset of a classic fixed-format instruction set: five register-to-register ALU operations, a word load, a word store, a branch on equality and an absolute jump.

Instruction and data storage are internal arrays. A loader port fills both arrays while reset is held low. After reset is released, the core runs on its own. It reports, every cycle, the current program counter, the register write it is about to commit and the store it is about to commit. An integrating environment can trace execution from these outputs without reaching into the core.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is sampled low, the program counter becomes 0 and all 32 registers become 0. No register write or store is reported in that state.
- R2: Opcode 0x00 is register format, with rs in bits 25:21, rt in bits 20:16, rd in bits 15:11 and the function code in bits 5:0. Function 0x20 adds, 0x22 subtracts, 0x24 is bitwise AND and 0x25 is bitwise OR. The result is written to rd.
- R3: Function 0x2A with opcode 0x00 writes 1 to rd when rs is less than rt as signed 32-bit numbers, and writes 0 otherwise.
- R4: Opcode 0x23 loads into rt the data word at index (rs + sign-extended bits 15:0) bits 7:2. The index wraps modulo the 64-word data array.
- R5: Opcode 0x2B stores rt at the same address that R4 computes. `dm_addr_o` shows the byte address and `dm_wdata_o` shows the stored value.
- R6: Opcode 0x04 compares rs with rt. When they are equal, the next PC is PC+4 plus the sign-extended bits 15:0 shifted left by 2. When they differ, the next PC is PC+4. Neither case writes a register or memory.
- R7: Opcode 0x02 sets the next PC to the top 4 bits of the current PC followed by bits 25:0 of the instruction and then two zero bits.
- R8: Register 0 reads as zero. A write aimed at it is dropped and is not reported on `rf_we_o`.
- R9: Any opcode outside the five above, and any register-format function code outside the five above, writes neither a register nor memory, and the PC advances by 4.
- R10: Except for a taken branch or a jump, the PC advances by exactly 4 every cycle. The instruction is fetched from word index PC bits 7:2, modulo the 64-word instruction array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_we | input | 1 | Loader write strobe, honoured only while reset is low |
| ld_to_data | input | 1 | Loader target: 0 writes the instruction array, 1 writes the data array |
| ld_addr | input | 6 | Loader word index |
| ld_data | input | 32 | Loader word |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| rf_we_o | output | 1 | A register write commits at the next edge |
| rf_waddr_o | output | 5 | Destination register of that write |
| rf_wdata_o | output | 32 | Value of that write |
| dm_we_o | output | 1 | A store commits at the next edge |
| dm_addr_o | output | 32 | Byte address of that store |
| dm_wdata_o | output | 32 | Value of that store |

## Verification
The bench fills both arrays with pseudo-random programs and data over several reset rounds. A software model of the instruction set runs beside the core, and each cycle the bench compares the PC, the reported register write and the reported store. The random pool of registers is kept small, so branches with rs equal to rt and destinations of register 0 occur often. A core that took the destination from rt on a register-format instruction, or from rd on a load, would report the wrong register. Other faults show up as a PC that diverges after a branch or a jump: a branch offset that is not shifted, or a jump that drops the top PC bits. A core that compares unsigned in set-less-than would report the wrong value when the operands differ in sign. A core that let unknown opcodes or unknown function codes write back would report a register write where the model expects none.

// File: rtl/sc_core_pkg.sv
// Shared encodings and control bundle for the single-cycle core.
// Assumes the fixed 32-bit instruction layout with the opcode in bits 31:26.
package sc_core_pkg;

    localparam logic [5:0] OPC_RFMT  = 6'h00;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_JMP   = 6'h02;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    // Operation class passed from the main decoder to the ALU control.
    typedef enum logic [1:0] {
        AC_ADD   = 2'b00,
        AC_SUB   = 2'b01,
        AC_FUNCT = 2'b10
    } alu_class_e;

    // Concrete ALU operation after function decode.
    typedef enum logic [2:0] {
        AF_ADD,
        AF_SUB,
        AF_AND,
        AF_OR,
        AF_SLT,
        AF_NONE
    } alu_fn_e;

    // Control bundle produced from the opcode.
    typedef struct packed {
        logic       reg_write;
        logic       dst_rd;
        logic       use_imm;
        logic       mem_write;
        logic       mem_to_reg;
        logic       branch;
        logic       jump;
        alu_class_e alu_class;
    } ctrl_t;

endpackage

// File: rtl/sc_ctrl_decode.sv
// Main control decoder: maps the 6-bit opcode onto the control bundle.
// Assumes unknown opcodes must behave as no-ops (no write of any kind).
module sc_ctrl_decode
    import sc_core_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctrl
);

    // Opcode to control lines; the default leaves every write disabled.
    always_comb begin
        ctrl = '{reg_write: 1'b0, dst_rd: 1'b0, use_imm: 1'b0,
                 mem_write: 1'b0, mem_to_reg: 1'b0, branch: 1'b0,
                 jump: 1'b0, alu_class: AC_ADD};
        case (opcode)
            OPC_RFMT: begin
                ctrl.reg_write = 1'b1;
                ctrl.dst_rd    = 1'b1;
                ctrl.alu_class = AC_FUNCT;
            end
            OPC_LOAD: begin
                ctrl.reg_write  = 1'b1;
                ctrl.use_imm    = 1'b1;
                ctrl.mem_to_reg = 1'b1;
            end
            OPC_STORE: begin
                ctrl.use_imm   = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.branch    = 1'b1;
                ctrl.alu_class = AC_SUB;
            end
            OPC_JMP: begin
                ctrl.jump = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sc_regbank.sv
// Register bank: two combinational read ports, one write port on the clock edge.
// Assumes synchronous active-low reset clears all entries; entry 0 is hard zero.
module sc_regbank #(
    parameter int NREG  = 32,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    ra_a,
    input  logic [AW-1:0]    ra_b,
    output logic [WIDTH-1:0] rd_a,
    output logic [WIDTH-1:0] rd_b,
    input  logic             we,
    input  logic [AW-1:0]    wa,
    input  logic [WIDTH-1:0] wd
);

    logic [WIDTH-1:0] regs [NREG];

    // Clear on reset, otherwise write any entry except 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    // Read ports, entry 0 forced to zero.
    always_comb begin
        rd_a = (ra_a == '0) ? '0 : regs[ra_a];
        rd_b = (ra_b == '0) ? '0 : regs[ra_b];
    end

endmodule

// File: rtl/sc_alu_unit.sv
// ALU with its control: picks the operation from the class and function code,
// and reports a zero result and whether the function code is supported.
// Assumes signed comparison for set-less-than.
module sc_alu_unit
    import sc_core_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_class_e       alu_class,
    input  logic [5:0]       funct,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y,
    output logic             zero,
    output logic             fn_ok
);

    alu_fn_e fn;

    // ALU control: class plus function code to concrete operation.
    always_comb begin
        fn = AF_NONE;
        case (alu_class)
            AC_ADD: fn = AF_ADD;
            AC_SUB: fn = AF_SUB;
            AC_FUNCT: begin
                case (funct)
                    FN_ADD:  fn = AF_ADD;
                    FN_SUB:  fn = AF_SUB;
                    FN_AND:  fn = AF_AND;
                    FN_OR:   fn = AF_OR;
                    FN_SLT:  fn = AF_SLT;
                    default: fn = AF_NONE;
                endcase
            end
            default: fn = AF_NONE;
        endcase
        fn_ok = (fn != AF_NONE);
    end

    // Datapath: compute the selected operation.
    always_comb begin
        case (fn)
            AF_ADD:  y = a + b;
            AF_SUB:  y = a - b;
            AF_AND:  y = a & b;
            AF_OR:   y = a | b;
            AF_SLT:  y = {{(WIDTH-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
        zero = (y == '0);
    end

endmodule

// File: rtl/sc_npc_unit.sv
// Next-PC selection: sequential, taken branch, or absolute jump.
// Assumes word-aligned PCs and a 32-bit address space.
module sc_npc_unit (
    input  logic [31:0] pc,
    input  logic [25:0] target,
    input  logic        take_branch,
    input  logic        jump,
    output logic [31:0] pc_next
);

    logic [31:0] pc_seq;
    logic [31:0] br_off;

    // Pick the next PC among the three sources.
    always_comb begin
        pc_seq = pc + 32'd4;
        br_off = {{14{target[15]}}, target[15:0], 2'b00};
        if (jump)
            pc_next = {pc[31:28], target, 2'b00};
        else if (take_branch)
            pc_next = pc_seq + br_off;
        else
            pc_next = pc_seq;
    end

endmodule

// File: rtl/sc_core.sv
// Single-cycle core top: PC register, instruction and data arrays, decode,
// register bank, ALU and next-PC logic. A loader port fills the arrays while
// reset is low. Assumes all state updates on the same rising edge.
module sc_core
    import sc_core_pkg::*;
#(
    parameter int IMEM_DEPTH = 64,
    parameter int DMEM_DEPTH = 64,
    localparam int IAW = $clog2(IMEM_DEPTH),
    localparam int DAW = $clog2(DMEM_DEPTH),
    localparam int LDW = (IAW > DAW) ? IAW : DAW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_we,
    input  logic            ld_to_data,
    input  logic [LDW-1:0]  ld_addr,
    input  logic [31:0]     ld_data,
    output logic [31:0]     pc_o,
    output logic            rf_we_o,
    output logic [4:0]      rf_waddr_o,
    output logic [31:0]     rf_wdata_o,
    output logic            dm_we_o,
    output logic [31:0]     dm_addr_o,
    output logic [31:0]     dm_wdata_o
);

    logic [31:0] imem [IMEM_DEPTH];
    logic [31:0] dmem [DMEM_DEPTH];

    logic [31:0] pc_q;
    logic [31:0] pc_next;
    logic [31:0] instr_w;
    ctrl_t       ctrl;
    logic [31:0] rs_val, rt_val;
    logic [31:0] imm_ext;
    logic [31:0] alu_b;
    logic [31:0] alu_y;
    logic        alu_zero;
    logic        fn_ok;
    logic [4:0]  dst;
    logic [31:0] load_val;
    logic        wb_en;
    logic        st_en;

    // Program counter: written on every edge, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    // Instruction array: written only by the loader during reset.
    always_ff @(posedge clk) begin
        if (!rst_n && ld_we && !ld_to_data) imem[ld_addr[IAW-1:0]] <= ld_data;
    end

    // Data array: loader during reset, core stores otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (ld_we && ld_to_data) dmem[ld_addr[DAW-1:0]] <= ld_data;
        end else if (st_en) begin
            dmem[alu_y[DAW+1:2]] <= rt_val;
        end
    end

    // Fetch, immediate, operand and destination selection.
    always_comb begin
        instr_w  = imem[pc_q[IAW+1:2]];
        imm_ext  = {{16{instr_w[15]}}, instr_w[15:0]};
        alu_b    = ctrl.use_imm ? imm_ext : rt_val;
        dst      = ctrl.dst_rd ? instr_w[15:11] : instr_w[20:16];
        load_val = dmem[alu_y[DAW+1:2]];
    end

    // Write-enable qualification for register bank and data array.
    always_comb begin
        wb_en = rst_n && ctrl.reg_write && (dst != 5'd0)
                && ((ctrl.alu_class != AC_FUNCT) || fn_ok);
        st_en = rst_n && ctrl.mem_write;
    end

    sc_ctrl_decode u_dec (
        .opcode (instr_w[31:26]),
        .ctrl   (ctrl)
    );

    sc_regbank #(.NREG(32), .WIDTH(32)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra_a  (instr_w[25:21]),
        .ra_b  (instr_w[20:16]),
        .rd_a  (rs_val),
        .rd_b  (rt_val),
        .we    (wb_en),
        .wa    (dst),
        .wd    (rf_wdata_o)
    );

    sc_alu_unit #(.WIDTH(32)) u_alu (
        .alu_class (ctrl.alu_class),
        .funct     (instr_w[5:0]),
        .a         (rs_val),
        .b         (alu_b),
        .y         (alu_y),
        .zero      (alu_zero),
        .fn_ok     (fn_ok)
    );

    sc_npc_unit u_npc (
        .pc          (pc_q),
        .target      (instr_w[25:0]),
        .take_branch (ctrl.branch && alu_zero),
        .jump        (ctrl.jump),
        .pc_next     (pc_next)
    );

    // Trace outputs.
    always_comb begin
        pc_o       = pc_q;
        rf_we_o    = wb_en;
        rf_waddr_o = dst;
        rf_wdata_o = ctrl.mem_to_reg ? load_val : alu_y;
        dm_we_o    = st_en;
        dm_addr_o  = alu_y;
        dm_wdata_o = rt_val;
    end

endmodule

// File: rtl/sc_core_checks.sv
// Property checker for sc_core, attached by bind below.
// Assumes synchronous active-low reset and the opcode values of the package.
module sc_core_checks
    import sc_core_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic        rf_we,
    input logic [4:0]  rf_waddr,
    input logic        dm_we
);

    logic [5:0] op;
    logic       op_known;

    always_comb begin
        op       = instr[31:26];
        op_known = (op == OPC_RFMT) || (op == OPC_LOAD) || (op == OPC_STORE)
                   || (op == OPC_BEQ) || (op == OPC_JMP);
    end

    p_pc_cleared_r1: assert property (@(posedge clk)
        !rst_n |=> (pc == 32'd0));

    p_store_only_sw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we |-> (op == OPC_STORE));

    p_jump_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OPC_JMP) |=> (pc == {$past(pc[31:28]), $past(instr[25:0]), 2'b00}));

    p_no_r0_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_waddr != 5'd0));

    p_unknown_noop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_known |-> (!rf_we && !dm_we));

    p_pc_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((op != OPC_BEQ) && (op != OPC_JMP)) |=> (pc == $past(pc) + 32'd4));

endmodule

bind sc_core sc_core_checks u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc       (pc_o),
    .instr    (instr_w),
    .rf_we    (rf_we_o),
    .rf_waddr (rf_waddr_o),
    .dm_we    (dm_we_o)
);

// File: tb/sc_core_tb_top.sv
`timescale 1ns/1ps
// Bench: random programs and data, an instruction-level model run in lockstep,
// and per-cycle comparison of PC, register write and store.
module sc_core_tb_top;

    localparam int DEPTH  = 64;
    localparam int ROUNDS = 6;
    localparam int CYCLES = 2500;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_we = 1'b0;
    logic        ld_to_data = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] pc_o;
    logic        rf_we_o;
    logic [4:0]  rf_waddr_o;
    logic [31:0] rf_wdata_o;
    logic        dm_we_o;
    logic [31:0] dm_addr_o;
    logic [31:0] dm_wdata_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] m_imem [DEPTH];
    logic [31:0] m_dmem [DEPTH];
    logic [31:0] m_reg  [32];
    logic [31:0] m_pc;

    always #4 clk = ~clk;

    sc_core dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_we      (ld_we),
        .ld_to_data (ld_to_data),
        .ld_addr    (ld_addr),
        .ld_data    (ld_data),
        .pc_o       (pc_o),
        .rf_we_o    (rf_we_o),
        .rf_waddr_o (rf_waddr_o),
        .rf_wdata_o (rf_wdata_o),
        .dm_we_o    (dm_we_o),
        .dm_addr_o  (dm_addr_o),
        .dm_wdata_o (dm_wdata_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rfmt(input int rs, input int rt, input int rd,
                                         input logic [5:0] fn);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction

    function automatic logic [31:0] ifmt(input logic [5:0] op, input int rs,
                                         input int rt, input logic [15:0] imm);
        return {op, rs[4:0], rt[4:0], imm};
    endfunction

    // Pseudo-random instruction with a small register pool.
    function automatic logic [31:0] gen_instr();
        int unsigned sel = $urandom % 16;
        int rs = $urandom % 8;
        int rt = $urandom % 8;
        int rd = $urandom % 8;
        logic [15:0] imm = 16'($urandom);
        logic [15:0] boff = 16'(int'($urandom % 9) - 4);
        case (sel)
            0, 14:   return rfmt(rs, rt, rd, 6'h20);
            1:       return rfmt(rs, rt, rd, 6'h22);
            2:       return rfmt(rs, rt, rd, 6'h24);
            3, 15:   return rfmt(rs, rt, rd, 6'h25);
            4:       return rfmt(rs, rt, rd, 6'h2A);
            5:       return rfmt(rs, rt, rd, 6'h27);
            6, 7:    return ifmt(6'h23, rs, rt, imm);
            8, 9:    return ifmt(6'h2B, rs, rt, imm);
            10, 11:  return ifmt(6'h04, rs, rt, boff);
            12:      return {6'h02, 20'($urandom), 6'($urandom % DEPTH)};
            default: return ifmt(6'h3F, rs, rt, imm);
        endcase
    endfunction

    // Compare the current cycle against the model, then advance the model.
    task automatic step_and_check();
        logic [31:0] w = m_imem[m_pc[7:2]];
        logic [5:0]  op = w[31:26];
        int          rs = int'(w[25:21]);
        int          rt = int'(w[20:16]);
        int          rd = int'(w[15:11]);
        logic [31:0] sx = {{16{w[15]}}, w[15:0]};
        logic [31:0] a = m_reg[rs];
        logic [31:0] b = m_reg[rt];
        logic [31:0] npc = m_pc + 32'd4;
        logic        ewe = 1'b0;
        int          edst = 0;
        logic [31:0] eval = '0;
        logic        esw = 1'b0;
        logic [31:0] eaddr = '0;
        string       tag = "R9";
        chk("R10", "pc", pc_o, m_pc);
        case (op)
            6'h00: begin
                ewe = 1'b1; edst = rd; tag = "R2";
                case (w[5:0])
                    6'h20: eval = a + b;
                    6'h22: eval = a - b;
                    6'h24: eval = a & b;
                    6'h25: eval = a | b;
                    6'h2A: begin eval = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R3"; end
                    default: begin ewe = 1'b0; tag = "R9"; end
                endcase
            end
            6'h23: begin
                ewe = 1'b1; edst = rt; tag = "R4";
                eaddr = a + sx; eval = m_dmem[eaddr[7:2]];
            end
            6'h2B: begin esw = 1'b1; eaddr = a + sx; tag = "R5"; end
            6'h04: begin
                tag = "R6";
                if (a == b) npc = m_pc + 32'd4 + {sx[29:0], 2'b00};
            end
            6'h02: begin tag = "R7"; npc = {m_pc[31:28], w[25:0], 2'b00}; end
            default: tag = "R9";
        endcase
        if (ewe && edst == 0) begin ewe = 1'b0; tag = "R8"; end
        chk(tag, "rf_we", 32'(rf_we_o), 32'(ewe));
        if (ewe) begin
            chk(tag, "rf_waddr", 32'(rf_waddr_o), 32'(edst));
            chk(tag, "rf_wdata", rf_wdata_o, eval);
            m_reg[edst] = eval;
        end
        chk(tag, "dm_we", 32'(dm_we_o), 32'(esw));
        if (esw) begin
            chk("R5", "dm_addr", dm_addr_o, eaddr);
            chk("R5", "dm_wdata", dm_wdata_o, b);
            m_dmem[eaddr[7:2]] = b;
        end
        m_pc = npc;
    endtask

    initial begin
        for (int r = 0; r < ROUNDS; r++) begin
            @(negedge clk);
            rst_n = 1'b0;
            for (int i = 0; i < DEPTH; i++) begin
                m_imem[i] = gen_instr();
                m_dmem[i] = (i % 5 == 0) ? 32'd7 : $urandom;
            end
            for (int i = 0; i < 32; i++) m_reg[i] = '0;
            m_pc = '0;
            for (int i = 0; i < 2 * DEPTH; i++) begin
                ld_we = 1'b1;
                ld_to_data = (i >= DEPTH);
                ld_addr = 6'(i % DEPTH);
                ld_data = (i >= DEPTH) ? m_dmem[i - DEPTH] : m_imem[i];
                @(negedge clk);
            end
            ld_we = 1'b0;
            @(negedge clk);
            // R1: reset state seen at the ports.
            chk("R1", "pc in reset", pc_o, 32'd0);
            chk("R1", "rf_we in reset", 32'(rf_we_o), 32'd0);
            chk("R1", "dm_we in reset", 32'(dm_we_o), 32'd0);
            rst_n = 1'b1;
            #1;
            for (int c = 0; c < CYCLES; c++) begin
                step_and_check();
                @(negedge clk);
                #1;
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule